// File: doc/BRIEF.md
# Inter-Master Send/Wait Synchronizer

This unit sits in a bus master's command sequencer and executes the two coordination commands that let several masters line up their bus traffic. Both commands are barriers: nothing happens until the master's count of outstanding bus transactions has fallen to zero.

A send command raises a chosen set of lines on a shared 32-line synch-out vector for one clock. It does this after a programmable number of cycles, counted from the drain. A wait command holds the sequencer until every line it selects on the shared synch-in vector is high in the same cycle. That line is only looked at after the drain.

Commands arrive one at a time over a valid/ready handshake. Each command carries an opcode, a level mask and a request delay. A single-cycle done strobe reports completion to the sequencer.

Top module: `syncBarrier`

## Requirements
- R1: `cmdReady` is high only when the unit is idle. A command is taken on a clock edge where `cmdValid` and `cmdReady` are both high. `cmdReady` is then low from the next cycle up to and including the cycle of `cmdDone`, and high again in the cycle after.
- R2: A send (`cmdIsWait`=0) drives no synch-out bit until `outstanding` has been sampled at zero on a clock edge after the command was taken.
- R3: Let E be the first edge after acceptance at which `outstanding` is zero. A send with delay D drives its pulse in the cycle that follows edge E+D. A delay of 0 therefore pulses in the cycle right after the drain is seen. `outstanding` is not looked at again once E has passed.
- R4: A send pulse lasts exactly one cycle. During it, `synchOut` equals the command's 32-bit mask, so several levels can be raised together. Bit i of the mask is level i.
- R5: `synchOut` is all zeros in every cycle that is not a send pulse. This includes the whole of every wait command.
- R6: A wait (`cmdIsWait`=1) ignores `synchIn` before edge E and in the cycle that ends at edge E. `synchIn` is only considered from the cycle after edge E onward.
- R7: A wait completes in the first considered cycle in which every bit set in its mask is high on `synchIn`. A cycle in which only some of the selected bits are high does not complete it.
- R8: `cmdDone` is a one-cycle strobe. For a send it is high in the pulse cycle. For a wait it is high in the cycle the condition is met.
- R9: A synchronous active-high `rst` returns the unit to idle. In that state `synchOut` is zero, `cmdDone` is low and `cmdReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | A command is offered |
| cmdReady | output | 1 | Unit idle and able to take a command |
| cmdIsWait | input | 1 | Opcode: 0 = send, 1 = wait |
| cmdMask | input | LEVELS (32) | Level mask; bit i selects level i |
| cmdDelay | input | DELAY_W (16) | Send request delay, in cycles after the drain |
| outstanding | input | OUTST_W (8) | Number of bus transactions still in flight |
| synchIn | input | LEVELS (32) | Incoming synchronization levels |
| synchOut | output | LEVELS (32) | Outgoing synchronization levels |
| cmdDone | output | 1 | One-cycle completion strobe |

## Verification
The bench uses the default parameters: 32 levels, a 16-bit delay and an 8-bit outstanding count. The full 32-bit width lets the tests use masks that touch level 31, level 0 and every line at once. The delays stay small, between 0 and 3 cycles, so that each cycle-exact timing can be checked at every step. The drain is put off by several cycles in some cases. That brings within reach a wait whose level is already high during the drain, and a wait that sees only some of its selected levels before the rest arrive.

// File: rtl/syncBarrierPkg.sv
package syncBarrierPkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DRAIN, S_DELAY, S_PULSE, S_WAIT
  } barState_t;

  typedef struct packed {
    logic capture;
    logic cntLoad;
    logic cntDec;
    logic pulse;
    logic done;
  } barStrobe_t;

  typedef struct packed {
    logic isWait;
    logic delayZero;
    logic cntLast;
    logic levelsMet;
  } barStatus_t;
endpackage

// File: rtl/syncBarrierCtrl.sv
module syncBarrierCtrl
  import syncBarrierPkg::*;
#(
  parameter int OUTST_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmdValid,
  input  logic [OUTST_W-1:0] outstanding,
  input  barStatus_t         stat,
  output barStrobe_t         strb,
  output logic               cmdReady,
  output logic               cmdDone
);
  barState_t state, nextState;
  logic drained;

  assign drained = (outstanding == '0);

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      S_IDLE: if (cmdValid) begin
        strb.capture = 1'b1;
        nextState    = S_DRAIN;
      end
      S_DRAIN: if (drained) begin
        if (stat.isWait)         nextState = S_WAIT;
        else if (stat.delayZero) nextState = S_PULSE;
        else begin
          strb.cntLoad = 1'b1;
          nextState    = S_DELAY;
        end
      end
      S_DELAY: begin
        strb.cntDec = 1'b1;
        if (stat.cntLast) nextState = S_PULSE;
      end
      S_PULSE: begin
        strb.pulse = 1'b1;
        strb.done  = 1'b1;
        nextState  = S_IDLE;
      end
      S_WAIT: if (stat.levelsMet) begin
        strb.done = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign cmdReady = (state == S_IDLE);
  assign cmdDone  = strb.done;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  // R2: a pending drain blocks the pulse
  p_no_early_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_DRAIN && !drained) |=> (state != S_PULSE));
  // R4: pulse lasts one cycle
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_PULSE) |=> (state != S_PULSE));
  // R8: done is a strobe
  p_done_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    cmdDone |=> !cmdDone);
  // R1: ready returns right after done
  p_ready_after_done_r1: assert property (@(posedge clk) disable iff (rst)
    cmdDone |=> cmdReady);
endmodule

// File: rtl/syncBarrierDpath.sv
module syncBarrierDpath
  import syncBarrierPkg::*;
#(
  parameter int LEVELS  = 32,
  parameter int DELAY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  barStrobe_t         strb,
  input  logic               cmdIsWait,
  input  logic [LEVELS-1:0]  cmdMask,
  input  logic [DELAY_W-1:0] cmdDelay,
  input  logic [LEVELS-1:0]  synchIn,
  output barStatus_t         stat,
  output logic [LEVELS-1:0]  synchOut
);
  localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

  logic               isWaitReg;
  logic [LEVELS-1:0]  maskReg;
  logic [DELAY_W-1:0] delayReg;
  logic [DELAY_W-1:0] delayCnt;
  logic [LEVELS-1:0]  levelHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      isWaitReg <= 1'b0;
      maskReg   <= '0;
      delayReg  <= '0;
      delayCnt  <= '0;
    end else begin
      if (strb.capture) begin
        isWaitReg <= cmdIsWait;
        maskReg   <= cmdMask;
        delayReg  <= cmdDelay;
      end
      if (strb.cntLoad)     delayCnt <= delayReg;
      else if (strb.cntDec) delayCnt <= delayCnt - ONE;
    end
  end

  for (genvar i = 0; i < LEVELS; i++) begin : g_level
    assign levelHit[i] = synchIn[i] | ~maskReg[i];
    assign synchOut[i] = strb.pulse & maskReg[i];
  end

  assign stat.isWait    = isWaitReg;
  assign stat.delayZero = (delayReg == '0);
  assign stat.cntLast   = (delayCnt == ONE);
  assign stat.levelsMet = &levelHit;

  // R7: a finished wait saw every selected level
  p_wait_all_levels_r7: assert property (@(posedge clk) disable iff (rst)
    (strb.done && isWaitReg) |-> ((synchIn & maskReg) == maskReg));
  // R3: countdown never wraps
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    strb.cntDec |-> (delayCnt != '0));
endmodule

// File: rtl/syncBarrier.sv
module syncBarrier
  import syncBarrierPkg::*;
#(
  parameter int LEVELS  = 32,
  parameter int DELAY_W = 16,
  parameter int OUTST_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic               cmdIsWait,
  input  logic [LEVELS-1:0]  cmdMask,
  input  logic [DELAY_W-1:0] cmdDelay,
  input  logic [OUTST_W-1:0] outstanding,
  input  logic [LEVELS-1:0]  synchIn,
  output logic [LEVELS-1:0]  synchOut,
  output logic               cmdDone
);
  barStrobe_t strb;
  barStatus_t stat;

  syncBarrierCtrl #(.OUTST_W(OUTST_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .outstanding(outstanding),
    .stat(stat), .strb(strb), .cmdReady(cmdReady), .cmdDone(cmdDone)
  );

  syncBarrierDpath #(.LEVELS(LEVELS), .DELAY_W(DELAY_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .cmdIsWait(cmdIsWait),
    .cmdMask(cmdMask), .cmdDelay(cmdDelay), .synchIn(synchIn),
    .stat(stat), .synchOut(synchOut)
  );

  // R5: an idle unit drives no level
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    cmdReady |-> (synchOut == '0));
endmodule

// File: tb/syncBarrier_bench.sv
module syncBarrier_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmdValid;
  logic        cmdReady;
  logic        cmdIsWait;
  logic [31:0] cmdMask;
  logic [15:0] cmdDelay;
  logic [7:0]  outstanding;
  logic [31:0] synchIn;
  logic [31:0] synchOut;
  logic        cmdDone;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  syncBarrier u_syncBarrier (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdIsWait(cmdIsWait), .cmdMask(cmdMask), .cmdDelay(cmdDelay),
    .outstanding(outstanding), .synchIn(synchIn), .synchOut(synchOut),
    .cmdDone(cmdDone)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // synchIn profile over step k: 0, then v1 on [a,b), 0 on [b,c), v2 from c
  function automatic logic [31:0] inAt(int k, int a, int b, int c,
                                       logic [31:0] v1, logic [31:0] v2);
    if (k < a)      return '0;
    else if (k < b) return v1;
    else if (k < c) return '0;
    else            return v2;
  endfunction

  // Command issued at step 0; outstanding is zero from step drainAt on.
  // expK is the step where the pulse (send) or the completion (wait) is due.
  task automatic runCmd(input string tag, input logic isW, input logic [31:0] mask,
                        input int dly, input int drainAt, input int a, input int b,
                        input int c, input logic [31:0] v1, input logic [31:0] v2,
                        input int expK);
    int outBad = 0, doneBad = 0, rdyBad = 0;
    logic [31:0] firstBadOut = '0;
    @(negedge clk);
    cmdValid    = 1'b1;
    cmdIsWait   = isW;
    cmdMask     = mask;
    cmdDelay    = 16'(dly);
    outstanding = (drainAt <= 0) ? 8'd0 : 8'd5;
    synchIn     = inAt(0, a, b, c, v1, v2);
    for (int k = 1; k <= expK + 1; k++) begin
      @(negedge clk);
      cmdValid    = 1'b0;
      cmdMask     = 32'hDEAD_BEEF;
      outstanding = (k >= drainAt) ? 8'd0 : 8'd5;
      synchIn     = inAt(k, a, b, c, v1, v2);
      #1;
      if (synchOut !== ((!isW && k == expK) ? mask : 32'd0)) begin
        if (outBad == 0) firstBadOut = synchOut;
        outBad++;
      end
      if (cmdDone !== (k == expK)) doneBad++;
      if (cmdReady !== (k > expK)) rdyBad++;
    end
    // R2 R4 R5 R6: levels driven only in the single pulse cycle
    check({tag, " R4/R5 synchOut profile"}, 32'(outBad), 32'd0);
    if (outBad != 0) $display("  first wrong synchOut=%h", firstBadOut);
    // R3 R7 R8: done exactly at the computed step
    check({tag, " R8 done timing"}, 32'(doneBad), 32'd0);
    // R1: busy window
    check({tag, " R1 ready window"}, 32'(rdyBad), 32'd0);
    outstanding = 8'd0;
    synchIn     = '0;
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1; cmdValid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0; rst = 1'b0;
    #1;
    check("R9 reset ready", 32'(cmdReady), 32'd1);
    check("R9 reset synchOut", synchOut, 32'd0);
    check("R9 reset done", 32'(cmdDone), 32'd0);
  endtask

  task automatic testSendNoDelay();  // R3 delay 0: pulse at step 2
    runCmd("send0", 1'b0, 32'h0000_0002, 0, 0, 0, 0, 0, 0, 0, 2);
  endtask

  task automatic testSendLateDrain();  // R2 R3: drain step 4, delay 3 -> step 8
    runCmd("sendLate", 1'b0, 32'h8000_0005, 3, 4, 0, 0, 0, 0, 0, 8);
  endtask

  task automatic testSendAllLevels();  // R4: all 32 levels, drain 2, delay 1 -> 4
    runCmd("sendAll", 1'b0, 32'hFFFF_FFFF, 1, 2, 0, 0, 0, 0, 0, 4);
  endtask

  task automatic testWaitIgnoreEarly();
    // R6: level high on steps 1..3 (drain seen at step 3) ignored; high again at 7
    runCmd("waitEarly", 1'b1, 32'h0000_0002, 0, 3, 1, 4, 7,
           32'h0000_0002, 32'h0000_0002, 7);
  endtask

  task automatic testWaitPartial();
    // R7: only bit 0 of 0x11 until step 6, both from step 6
    runCmd("waitPart", 1'b1, 32'h0000_0011, 0, 0, 0, 6, 6,
           32'h0000_0001, 32'h0000_0011, 6);
  endtask

  task automatic testWaitHeld();
    // R6 R7: level 31 held high throughout, drain at 2 -> first considered step 3
    runCmd("waitHeld", 1'b1, 32'h8000_0000, 0, 2, 0, 40, 40,
           32'h8000_0000, 32'h8000_0000, 3);
  endtask

  initial begin
    rst = 1'b1; cmdValid = 1'b0; cmdIsWait = 1'b0; cmdMask = '0;
    cmdDelay = '0; outstanding = '0; synchIn = '0;
    testReset();
    testSendNoDelay();
    testSendLateDrain();
    testSendAllLevels();
    testWaitIgnoreEarly();
    testWaitPartial();
    testWaitHeld();
    testSendNoDelay();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule